// File: doc/BRIEF.md
# Five-Channel Prescaled PWM Timer

This peripheral holds five independent down-counters. All of them run from one input clock, which passes through a shared front-end before it reaches them. The front-end has two 8-bit prescalers: one serves channels 0 and 1, the other serves channels 2, 3 and 4. Behind the prescalers, each channel has its own power-of-two divider. Each channel keeps a buffered count value and a buffered compare value. Software copies these buffers into the running counter with a manual-update bit. It then starts the channel, either as a one-shot or with automatic reload.

When a channel's counter decrements from zero, that event is an underflow. An underflow sets the channel's pending flag. The interrupt output for a channel is asserted when both its pending flag and its enable bit are set. Each channel also drives a PWM-style output level, derived from the counter and the compare value. Software reads the live count through a per-channel observation address. The counter runs downward, so software inverts the value it reads to get a rising timestamp.

The register interface is a single-cycle write strobe and a combinational read. The counter width is a parameter, either 16 or 32 bits. With a 16-bit counter, every divider setting divides by twice as much as with a 32-bit counter.

Top module: `quint_pwm_timer`

## Requirements
- R1: After reset the following hold:
  - every register reads zero;
  - `irq_out` is 0;
  - `pwm_out` is 5'b11111, because a zero count is not above a zero compare.
- R2: The prescaler register sits at offset 0x00. Bits 7:0 (value P0) feed channels 0 and 1. Bits 15:8 (value P1) feed channels 2 to 4. Each group divides the input clock by its P+1.
- R3: The divider register sits at offset 0x04 and holds a 4-bit code for channel c at bits 4c+3:4c.
  - The channel tick rate is the group prescaler output divided by 2^(min(code,4)+B).
  - B is 1 when CNT_W is 16 and 0 otherwise.
- R4: The control register sits at offset 0x08.
  - Channel 0 uses bits 3:0. Channel n ≥ 1 uses bits 4(n+1)+3:4(n+1).
  - Within a nibble: bit 0 is start, bit 1 is manual update, bit 2 is invert, bit 3 is autoreload.
  - Bits 7:4 and 31:24 always read zero.
- R5: Channel 4's nibble is bits 23:20. Its bit 2 is autoreload. Channel 4 has no invert control, and bit 23 reads zero.
- R6: Buffer addresses and widths:
  - The count buffer of channel c is at 0x0C+12c. The compare buffer of channels 0 to 3 is at 0x10+12c.
  - Channel 4 has no compare buffer; its compare value is fixed at zero.
  - Buffers keep the low CNT_W bits of a write, and the upper bits read zero.
- R7: While a channel's manual-update bit is set, the channel does the following:
  - it copies both buffers into the counter and the active compare value on every cycle, and does not count;
  - its live count reads at 0x14+12c for channels 0 to 3, and at 0x40 for channel 4.
- R8: When start is set and manual update is clear, the counter decrements by one on each channel tick. When start is clear, the counter holds its value.
- R9: With autoreload clear, a channel stops after its underflow:
  - the counter stays at 0;
  - the hardware clears the channel's start bit;
  - no further underflow occurs.
- R10: With autoreload set, each underflow reloads the count buffer and the compare buffer. A count value N then gives an underflow every (N+1)·(P+1)·2^(min(code,4)+B) clock cycles.
- R11: The interrupt register sits at offset 0x44.
  - Bits 4:0 are read/write enables.
  - Bits 9:5 are pending flags. A channel's flag is set on its underflow whether or not its enable is set, and is cleared by writing one to it. An underflow in the same cycle as the clear wins.
  - `irq_out[c]` is enable c AND pending c.
- R12: `pwm_out[c]` equals (count ≤ active compare) XOR the channel's invert bit.
- R13: The full range up to 2^CNT_W−1 can be loaded and observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 7 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | 5 | Per-channel PWM level |
| irq_out | output | 5 | Per-channel interrupt request |

## Verification
The hardest state to reach from the ports is a running channel whose tick period has to be measured exactly. The prescaler and divider counters run freely, so the phase at which a channel starts is unknown. Measuring the time from start to the first underflow would therefore be unreliable. The bench instead runs a channel with autoreload and waits for one underflow. It clears the pending flag, then counts cycles to the next underflow. The gap must equal the exact product of the count, the prescaler and the divider. Random trials pick the channel (including channel 4 with its moved autoreload bit), the prescale value, the divider code (including codes above the clamp) and the count. Directed cases cover the following:
- control-word layout;
- buffer truncation;
- the one-shot stop;
- pending flags that are set while their enable is off.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
    localparam int NCH         = 5;
    localparam int AW          = 7;
    localparam int DIV_SEL_MAX = 4;

    localparam logic [AW-1:0] A_PRESC  = 7'h00;
    localparam logic [AW-1:0] A_DIVSEL = 7'h04;
    localparam logic [AW-1:0] A_CTRL   = 7'h08;
    localparam logic [AW-1:0] A_IRQ    = 7'h44;
    localparam logic [AW-1:0] A_OBS_LAST = 7'h40;

    typedef struct packed {
        logic start;
        logic manual;
        logic invert;
        logic reload;
    } chan_ctl_t;

    // Nibble position inside the control word (one unused slot after channel 0)
    function automatic int ctl_base(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    function automatic logic [AW-1:0] cnt_addr(input int ch);
        return AW'(12 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] cmp_addr(input int ch);
        return AW'(16 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] obs_addr(input int ch);
        return (ch == NCH - 1) ? A_OBS_LAST : AW'(20 + 12 * ch);
    endfunction
endpackage

// File: rtl/qpt_tick_gen.sv
module qpt_tick_gen
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][7:0]       presc,
    input  logic [NCH-1:0][3:0]   divsel,
    output logic [NCH-1:0]        tick
);
    localparam int DIV_BASE = (CNT_W == 16) ? 1 : 0;
    localparam int DIVW     = DIV_SEL_MAX + DIV_BASE;

    typedef struct packed {
        logic [1:0][7:0]      pre;
        logic [1:0][DIVW-1:0] div;
    } tg_t;

    tg_t        tg_d, tg_q;
    logic [1:0] pre_tick;

    function automatic logic [DIVW-1:0] sel_mask(input logic [3:0] s);
        int lg;
        lg = ((int'(s) > DIV_SEL_MAX) ? DIV_SEL_MAX : int'(s)) + DIV_BASE;
        return DIVW'((1 << lg) - 1);
    endfunction

    always_comb begin
        tg_d = tg_q;
        for (int g = 0; g < 2; g++) begin
            pre_tick[g]  = (tg_q.pre[g] >= presc[g]);
            tg_d.pre[g]  = pre_tick[g] ? 8'd0 : tg_q.pre[g] + 8'd1;
            tg_d.div[g]  = tg_q.div[g] + DIVW'(pre_tick[g]);
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_tick
            localparam int GRP = (c < 2) ? 0 : 1;
            logic [DIVW-1:0] m;
            assign m       = sel_mask(divsel[c]);
            assign tick[c] = pre_tick[GRP] && ((tg_q.div[GRP] & m) == m);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end
endmodule

// File: rtl/qpt_channel.sv
module qpt_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             manual,
    input  logic             reload,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] count,
    output logic             underflow,
    output logic             pwm
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } ch_t;

    ch_t  ch_d, ch_q;
    logic run;

    always_comb begin
        ch_d      = ch_q;
        run       = start && !manual;
        underflow = run && tick && (ch_q.cnt == '0);
        if (manual) begin
            ch_d.cnt = cnt_buf;
            ch_d.cmp = cmp_buf;
        end else if (run && tick) begin
            if (ch_q.cnt != '0) begin
                ch_d.cnt = ch_q.cnt - 1'b1;
            end else if (reload) begin
                ch_d.cnt = cnt_buf;
                ch_d.cmp = cmp_buf;
            end
        end
    end

    assign count = ch_q.cnt;
    assign pwm   = (ch_q.cnt <= ch_q.cmp) ^ invert;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end
endmodule

// File: rtl/quint_pwm_timer.sv
module quint_pwm_timer
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] irq_out
);
    localparam int LAST = NCH - 1;

    typedef struct packed {
        logic [1:0][7:0]             presc;
        logic [NCH-1:0][3:0]         divsel;
        chan_ctl_t [NCH-1:0]         ctl;
        logic [NCH-1:0][CNT_W-1:0]   cnt_buf;
        logic [NCH-1:0][CNT_W-1:0]   cmp_buf;
        logic [NCH-1:0]              irq_en;
        logic [NCH-1:0]              irq_pend;
    } regs_t;

    regs_t r_d, r_q;

    logic [NCH-1:0]            ch_tick;
    logic [NCH-1:0]            ch_uf;
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;
    logic [NCH-1:0]            start_v, manual_v, reload_v, pend_v;

    // Next-state of the register file
    always_comb begin
        r_d = r_q;
        for (int c = 0; c < NCH; c++) begin
            if (ch_uf[c] && !r_q.ctl[c].reload) r_d.ctl[c].start = 1'b0;
        end
        if (wr_en) begin
            if (addr == A_PRESC) r_d.presc = wdata[15:0];
            if (addr == A_DIVSEL) begin
                for (int c = 0; c < NCH; c++) r_d.divsel[c] = wdata[4*c +: 4];
            end
            if (addr == A_CTRL) begin
                for (int c = 0; c < NCH; c++) begin
                    r_d.ctl[c].start  = wdata[ctl_base(c)];
                    r_d.ctl[c].manual = wdata[ctl_base(c) + 1];
                    if (c == LAST) begin
                        r_d.ctl[c].invert = 1'b0;
                        r_d.ctl[c].reload = wdata[ctl_base(c) + 2];
                    end else begin
                        r_d.ctl[c].invert = wdata[ctl_base(c) + 2];
                        r_d.ctl[c].reload = wdata[ctl_base(c) + 3];
                    end
                end
            end
            if (addr == A_IRQ) begin
                r_d.irq_en   = wdata[NCH-1:0];
                r_d.irq_pend = r_q.irq_pend & ~wdata[2*NCH-1:NCH];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == cnt_addr(c)) r_d.cnt_buf[c] = wdata[CNT_W-1:0];
                if (c != LAST && addr == cmp_addr(c)) r_d.cmp_buf[c] = wdata[CNT_W-1:0];
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_uf[c]) r_d.irq_pend[c] = 1'b1;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == A_PRESC) rdata[15:0] = r_q.presc;
        if (addr == A_DIVSEL) begin
            for (int c = 0; c < NCH; c++) rdata[4*c +: 4] = r_q.divsel[c];
        end
        if (addr == A_CTRL) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[ctl_base(c)]     = r_q.ctl[c].start;
                rdata[ctl_base(c) + 1] = r_q.ctl[c].manual;
                if (c == LAST) begin
                    rdata[ctl_base(c) + 2] = r_q.ctl[c].reload;
                end else begin
                    rdata[ctl_base(c) + 2] = r_q.ctl[c].invert;
                    rdata[ctl_base(c) + 3] = r_q.ctl[c].reload;
                end
            end
        end
        if (addr == A_IRQ) begin
            rdata[NCH-1:0]     = r_q.irq_en;
            rdata[2*NCH-1:NCH] = r_q.irq_pend;
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == cnt_addr(c)) rdata[CNT_W-1:0] = r_q.cnt_buf[c];
            if (c != LAST && addr == cmp_addr(c)) rdata[CNT_W-1:0] = r_q.cmp_buf[c];
            if (addr == obs_addr(c)) rdata[CNT_W-1:0] = ch_cnt[c];
        end
    end

    qpt_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .presc  (r_q.presc),
        .divsel (r_q.divsel),
        .tick   (ch_tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            qpt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (ch_tick[c]),
                .start     (r_q.ctl[c].start),
                .manual    (r_q.ctl[c].manual),
                .reload    (r_q.ctl[c].reload),
                .invert    (r_q.ctl[c].invert),
                .cnt_buf   (r_q.cnt_buf[c]),
                .cmp_buf   (r_q.cmp_buf[c]),
                .count     (ch_cnt[c]),
                .underflow (ch_uf[c]),
                .pwm       (pwm_out[c])
            );
            assign start_v[c]  = r_q.ctl[c].start;
            assign manual_v[c] = r_q.ctl[c].manual;
            assign reload_v[c] = r_q.ctl[c].reload;
            assign pend_v[c]   = r_q.irq_pend[c];
        end
    endgenerate

    assign irq_out = r_q.irq_en & r_q.irq_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/qpt_checker.sv
module qpt_checker
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             addr,
    input logic [31:0]               wdata,
    input logic [NCH-1:0]            tick,
    input logic [NCH-1:0]            uf,
    input logic [NCH-1:0]            start,
    input logic [NCH-1:0]            manual,
    input logic [NCH-1:0]            reload,
    input logic [NCH-1:0]            pend,
    input logic [NCH-1:0][CNT_W-1:0] cnt
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            // R8: a running channel steps down by one per tick
            a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
                start[c] && !manual[c] && tick[c] && cnt[c] != '0
                |=> cnt[c] == CNT_W'($past(cnt[c]) - 1'b1));

            // R8: a stopped channel holds its count
            a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
                !start[c] && !manual[c] |=> $stable(cnt[c]));

            // R9: one-shot underflow drops the start bit
            a_r9_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
                uf[c] && !reload[c] && !(wr_en && addr == A_CTRL) |=> !start[c]);

            // R11: underflow raises the pending flag
            a_r11_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
                uf[c] |=> pend[c]);

            // R11: pending stays until a matching one is written
            a_r11_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                pend[c] && !(wr_en && addr == A_IRQ && wdata[NCH + c]) |=> pend[c]);
        end
    endgenerate
endmodule

bind quint_pwm_timer qpt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .tick   (ch_tick),
    .uf     (ch_uf),
    .start  (start_v),
    .manual (manual_v),
    .reload (reload_v),
    .pend   (pend_v),
    .cnt    (ch_cnt)
);

// File: tb/quint_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module quint_pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  pwm_out, irq_out;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quint_pwm_timer #(.CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] cw(input int c, input bit st, input bit mu, input bit inv, input bit rl);
        int b;
        logic [31:0] w;
        b = (c == 0) ? 0 : 4 * c + 4;
        w = '0;
        w[b] = st;
        w[b+1] = mu;
        if (c == 4) w[b+2] = rl;
        else begin w[b+2] = inv; w[b+3] = rl; end
        return w;
    endfunction

    function automatic logic [6:0] a_cnt(input int c); return 7'(12 + 12*c); endfunction
    function automatic logic [6:0] a_cmp(input int c); return 7'(16 + 12*c); endfunction
    function automatic logic [6:0] a_obs(input int c); return (c == 4) ? 7'h40 : 7'(20 + 12*c); endfunction

    function automatic int unsigned period_exp(input int p, input int sel, input int n);
        int k;
        k = ((sel > 4) ? 4 : sel) + 1;
        return (n + 1) * (p + 1) * (1 << k);
    endfunction

    task automatic wait_irq(input int c, output int unsigned t, output bit ok);
        int n = 0;
        while (!irq_out[c] && n < 20000) begin @(negedge clk); n++; end
        ok = irq_out[c];
        t  = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned t0, t1;
        bit ok;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pwm_out after reset", 32'(pwm_out), 32'h1F);
        check("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd(7'h00, v); check("R1 prescaler reg", v, 0);
        rd(7'h04, v); check("R1 divider reg", v, 0);
        rd(7'h08, v); check("R1 control reg", v, 0);
        rd(7'h44, v); check("R1 interrupt reg", v, 0);
        rd(7'h40, v); check("R1 ch4 observation", v, 0);

        // R4 / R5: control word layout and unused bits
        wr(7'h08, 32'hFFFF_FFFF);
        rd(7'h08, v); check("R4 R5 control readback", v, 32'h007F_FF0F);
        wr(7'h08, 32'h0);

        // R6 / R13: buffer truncation and full-range load
        wr(a_cnt(0), 32'hFFFF_FFFF);
        rd(a_cnt(0), v); check("R6 count buffer truncated", v, 32'h0000_FFFF);
        wr(7'h08, cw(0, 0, 1, 0, 0));
        repeat (2) @(negedge clk);
        rd(a_obs(0), v); check("R13 R7 max count observed", v, 32'h0000_FFFF);
        wr(7'h08, 32'h0);

        // R12: output level versus compare, with invert
        wr(a_cnt(1), 10);
        wr(a_cmp(1), 5);
        rd(a_cmp(1), v); check("R6 compare buffer readback", v, 5);
        wr(7'h08, cw(1, 0, 1, 0, 0));
        repeat (2) @(negedge clk);
        check("R12 count above compare", 32'(pwm_out[1]), 0);
        wr(7'h08, cw(1, 0, 1, 1, 0));
        repeat (2) @(negedge clk);
        check("R12 inverted level", 32'(pwm_out[1]), 1);
        wr(a_cnt(1), 3);
        repeat (2) @(negedge clk);
        rd(a_obs(1), v); check("R7 manual update follows buffer", v, 3);
        check("R12 count below compare inverted", 32'(pwm_out[1]), 0);
        wr(7'h08, 32'h0);

        // R5: channel 4 nibble bit 2 is autoreload, not invert
        wr(a_cnt(4), 5);
        wr(7'h08, cw(4, 0, 1, 0, 1));
        repeat (2) @(negedge clk);
        check("R5 ch4 no invert", 32'(pwm_out[4]), 0);
        rd(7'h40, v); check("R7 ch4 observation address", v, 5);
        wr(7'h08, 32'h0);
        repeat (50) @(negedge clk);
        rd(7'h40, v); check("R8 stopped channel holds", v, 5);

        // R9: one-shot on channel 2
        wr(7'h00, 32'h0);
        wr(7'h04, 32'h0);
        wr(a_cnt(2), 4);
        wr(7'h08, cw(2, 0, 1, 0, 0));
        wr(7'h08, cw(2, 1, 0, 0, 0));
        wr(7'h44, 32'h3E0 | 32'h4);
        wait_irq(2, t0, ok);
        check("R9 one-shot underflow seen", 32'(ok), 1);
        rd(7'h08, v); check("R9 start bit cleared", v & 32'h1000, 0);
        rd(a_obs(2), v); check("R9 counter parked at zero", v, 0);
        rd(7'h44, v); check("R11 pending bit readback", v, 32'h84);
        wr(7'h44, 32'h4 | 32'h80);
        repeat (100) @(negedge clk);
        check("R9 no second underflow", 32'(irq_out[2]), 0);
        rd(7'h44, v); check("R11 pending cleared by write-one", v, 32'h4);

        // R11: pending set while enable is off
        wr(a_cnt(3), 3);
        wr(7'h44, 32'h3E0);
        wr(7'h08, cw(3, 0, 1, 0, 0));
        wr(7'h08, cw(3, 1, 0, 0, 1));
        repeat (200) @(negedge clk);
        rd(7'h44, v); check("R11 pending with enable off", v, 32'h100);
        check("R11 irq gated by enable", 32'(irq_out), 0);
        wr(7'h08, 32'h0);
        wr(7'h44, 32'h3E0);

        // R2 R3 R10: random autoreload period trials
        for (int t = 0; t < 10; t++) begin
            int c, p, sel, n, other;
            c = $urandom_range(4, 0);
            if (t == 0) c = 4;
            p = $urandom_range(3, 0);
            sel = $urandom_range(6, 0);
            n = $urandom_range(9, 2);
            other = $urandom_range(255, 0);
            wr(7'h00, (c < 2) ? ((other << 8) | p) : ((p << 8) | other));
            wr(7'h04, sel << (4 * c));
            wr(a_cnt(c), n);
            wr(7'h08, cw(c, 0, 1, 0, 0));
            wr(7'h08, cw(c, 1, 0, 0, 1));
            wr(7'h44, 32'h3E0 | (1 << c));
            wait_irq(c, t0, ok);
            wr(7'h44, (1 << c) | (1 << (c + 5)));
            wait_irq(c, t1, ok);
            check($sformatf("R10 R2 R3 period ch%0d p%0d sel%0d n%0d", c, p, sel, n),
                  t1 - t0, period_exp(p, sel, n));
            check("R10 autoreload keeps running", 32'(ok), 1);
            wr(7'h08, 32'h0);
            wr(7'h44, 32'h3E0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule